// File: doc/BRIEF.md
# Watchdog Timer with Sticky Overflow Status

This block guards a chip against runaway firmware. A free-running prescaler divides the system clock down to a slow tick, and a 4-bit counter counts those ticks. Firmware must service the watchdog before the counter runs past its top value. If it does not, the block raises a chip-reset request for a fixed number of cycles and sets an overflow flag.

Firmware sees two byte-wide registers on a simple address/write bus. The status register is read-only. It returns the overflow flag and the live count. The service register is write-only. Setting its top bit restarts the prescaler and the counter and clears the flag.

The overflow flag is sticky across the reset that the watchdog itself requests. After restart, firmware can therefore tell a watchdog recovery from a cold start. Only the external power-on reset or a service write clears the flag. With the default prescaler of 2^18 cycles per tick, a 6 MHz clock gives a timeout of about 0.7 s.

Top module: `sticky_wdog`

## Requirements
- R1: While `rst_n` is low, the prescaler, the counter, the flag and the pulse logic return to zero. The status register reads 0x00 and `wdog_rst_o` is low.
- R2: A read at STAT_ADDR (default 0xDE) returns the flag in bit 7 and the count in bits 3..0, with bits 6..4 at 0. A read at any other address, including CLR_ADDR (default 0xDF), returns 0x00. Reads are combinational.
- R3: The counter advances by one on each prescaler tick. One tick occurs every 2^PRE_W clock cycles, counted from reset, from a service write, or from the end of a reset pulse.
- R4: On a tick that finds the count at 15, the counter returns to 0 and the flag is set. `wdog_rst_o` rises at that same clock edge.
- R5: `wdog_rst_o` stays high for exactly PULSE_LEN cycles. During the pulse the prescaler and the counter are held at zero, and no new overflow can start.
- R6: Once set, the flag stays set through the reset pulse and afterwards. It clears only on R1 or on a service write.
- R7: A service write is a write to CLR_ADDR with bit 7 = 1. At that edge the counter and the prescaler become 0 and the flag clears. A service write takes priority over an overflow in the same cycle. A pulse that is already running completes.
- R8: A write to CLR_ADDR with bit 7 = 0 has no effect. A write to any other address, including STAT_ADDR, also has no effect.
- R9: Asserting `rst_n` after a watchdog overflow clears the sticky flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| wdog_rst_o | output | 1 | Chip-reset request pulse |

## Verification
The assertions assume the following about the inputs:
- `bus_wr`, `bus_addr` and `bus_wdata` are stable around each rising edge.
- `rst_n` is held low for at least one full clock edge.
- The counter width leaves bit 7 free for the flag.

The stimulus meets these conditions by changing every input only on the falling edge and by holding reset across two edges. Within that envelope, the bench steers a service write onto the exact cycle of an overflow. It also issues a service write inside a running pulse and a power-on reset while the flag is set. A behavioural reference model is compared on every cycle.

// File: rtl/sticky_wdog_pkg.sv
package sticky_wdog_pkg;

    localparam int DATA_W   = 8;
    localparam int KICK_BIT = 7;
    localparam int FLAG_BIT = 7;

    localparam logic [7:0] DEF_STAT_ADDR = 8'hDE;
    localparam logic [7:0] DEF_CLR_ADDR  = 8'hDF;

    // Status byte: flag on top, count in the low bits, the rest zero.
    function automatic logic [DATA_W-1:0] pack_status(input logic flag,
                                                      input logic [FLAG_BIT-1:0] cnt);
        logic [DATA_W-1:0] v;
        v = '0;
        v[FLAG_BIT] = flag;
        v[FLAG_BIT-1:0] = cnt;
        return v;
    endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int PRE_W = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam logic [PRE_W-1:0] PRE_MAX = '1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.pre = '0;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = (s_q.pre == PRE_MAX);

    // R3: two ticks are never adjacent.
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R7: a clear leaves no tick in the following cycle.
    a_r7_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !tick_o);

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic    ovf;

    always_comb begin
        s_d = s_q;
        ovf = 1'b0;
        if (kick_i || hold_i) begin
            s_d.cnt = '0;
        end else if (tick_i) begin
            ovf     = (s_q.cnt == CNT_MAX);
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
    assign ovf_o = ovf;

    // R3: without a tick, a service write or a hold, the count does not move.
    a_r3_count_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !kick_i && !hold_i) |=> $stable(s_q.cnt));

    // R4: an overflow leaves the counter at zero.
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_o == '0));

    // R5: the count stays at zero while held.
    a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (cnt_o == '0));

endmodule

// File: rtl/wdog_flag.sv
module wdog_flag #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic kick_i,
    output logic flag_o,
    output logic pulse_o
);
    localparam int RW = $clog2(PULSE_LEN + 1);
    localparam logic [RW-1:0] REM_LOAD = RW'(PULSE_LEN);
    localparam logic [RW-1:0] REM_ONE  = RW'(1);

    typedef struct packed {
        logic          flag;
        logic [RW-1:0] rem;
    } flag_st_t;

    flag_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (kick_i) begin
            s_d.flag = 1'b0;
        end else if (ovf_i) begin
            s_d.flag = 1'b1;
        end
        if (ovf_i) begin
            s_d.rem = REM_LOAD;
        end else if (s_q.rem != '0) begin
            s_d.rem = s_q.rem - REM_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag_o  = s_q.flag;
    assign pulse_o = (s_q.rem != '0);

    // R4: an overflow sets the flag and starts the pulse.
    a_r4_flag_and_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> (flag_o && pulse_o));

    // R5: no overflow is reported while a pulse is running.
    a_r5_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> !ovf_i);

    // R6: the flag holds until a service write.
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !kick_i) |=> flag_o);

    // R8: the flag never rises without an overflow.
    a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !ovf_i) |=> !flag_o);

endmodule

// File: rtl/sticky_wdog.sv
module sticky_wdog
    import sticky_wdog_pkg::*;
#(
    parameter int             PRE_W     = 18,
    parameter int             CNT_W     = 4,
    parameter int             PULSE_LEN = 4,
    parameter int             ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(DEF_STAT_ADDR),
    parameter logic [ADDR_W-1:0] CLR_ADDR  = ADDR_W'(DEF_CLR_ADDR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              wdog_rst_o
);
    logic             kick;
    logic             tick;
    logic             ovf;
    logic             pulse;
    logic             flag;
    logic             pre_clr;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        kick    = bus_wr && (bus_addr == CLR_ADDR) && bus_wdata[KICK_BIT];
        pre_clr = kick || pulse;
    end

    wdog_prescale #(.PRE_W(PRE_W)) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (pre_clr),
        .tick_o (tick)
    );

    wdog_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .kick_i (kick),
        .hold_i (pulse),
        .cnt_o  (cnt),
        .ovf_o  (ovf)
    );

    wdog_flag #(.PULSE_LEN(PULSE_LEN)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf_i   (ovf),
        .kick_i  (kick),
        .flag_o  (flag),
        .pulse_o (pulse)
    );

    always_comb begin
        if (bus_addr == STAT_ADDR) begin
            bus_rdata = pack_status(flag, (FLAG_BIT)'(cnt));
        end else begin
            bus_rdata = '0;
        end
    end

    assign wdog_rst_o = pulse;

    // R7: a service write leaves the count at zero and the flag clear.
    a_r7_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0 && !flag));

    // R7: a service write in the overflow cycle suppresses the pulse.
    a_r7_kick_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !pulse) |=> !wdog_rst_o);

    // R2: the status byte keeps bits 6..4 at zero.
    a_r2_status_gap: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[6:4] == 3'b000);

endmodule

// File: tb/sticky_wdog_bench.sv
module sticky_wdog_bench;
    localparam int PRE_W = 3;
    localparam int M     = 1 << PRE_W;
    localparam int CMAX  = 15;
    localparam int L     = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'hDE;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wdog_rst_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // reference model state
    int  m_pre = 0, m_cnt = 0, m_left = 0;
    bit  m_flag = 0;

    always #4 clk = ~clk;

    sticky_wdog #(.PRE_W(PRE_W), .PULSE_LEN(L)) u_sticky_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .wdog_rst_o (wdog_rst_o)
    );

    task automatic check(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int exp_read();
        if (bus_addr == 8'hDE) return (m_flag ? 128 : 0) + m_cnt;
        return 0;
    endfunction

    task automatic model_step();
        bit kick, tick, ovf;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_flag = 0; m_left = 0;
            return;
        end
        kick = bus_wr && bus_addr == 8'hDF && bus_wdata[7];
        tick = (m_pre == M - 1) && m_left == 0;
        ovf  = tick && m_cnt == CMAX && !kick;
        m_pre = (kick || m_left > 0) ? 0 : (m_pre + 1) % M;
        if (kick || m_left > 0) m_cnt = 0;
        else if (tick) m_cnt = (m_cnt + 1) % (CMAX + 1);
        if (kick) m_flag = 0;
        else if (ovf) m_flag = 1;
        if (ovf) m_left = L;
        else if (m_left > 0) m_left--;
    endtask

    // one clock: inputs already driven, model follows the edge, compare at negedge
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cycles++;
        check("R2 read", bus_rdata, exp_read());
        check("R5 pulse", wdog_rst_o, m_left > 0);
    endtask

    task automatic idle(input int n);
        bus_wr = 0; bus_addr = 8'hDE; bus_wdata = 0;
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 0; bus_addr = 8'hDE; bus_wdata = 0;
    endtask

    task automatic count_pulse(output int n);
        n = 1;
        while (wdog_rst_o && n < 50) begin
            idle(1);
            if (wdog_rst_o) n++;
        end
    endtask

    initial begin : watchdog
        #(8 * 20000);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        int n;
        rst_n = 0;
        cyc(); cyc();
        check("R1 reset read", bus_rdata, 8'h00);
        check("R1 reset pulse", wdog_rst_o, 0);
        rst_n = 1;

        idle(8);  check("R3 first tick", bus_rdata, 8'h01);
        idle(7);  check("R3 no early tick", bus_rdata, 8'h01);
        idle(1);  check("R3 second tick", bus_rdata, 8'h02);
        idle(111); check("R4 before overflow", bus_rdata, 8'h0F);
        check("R4 no pulse yet", wdog_rst_o, 0);
        idle(1);  check("R4 flag set count zero", bus_rdata, 8'h80);
        check("R4 pulse rises", wdog_rst_o, 1);
        count_pulse(n);
        check("R5 pulse length", n, L);
        check("R6 flag after pulse", bus_rdata, 8'h80);
        idle(50);
        check("R6 flag sticky", bus_rdata[7], 1);

        wr(8'hDF, 8'h7F);
        idle(1); check("R8 bit7 zero ignored", bus_rdata[7], 1);
        wr(8'hDE, 8'hFF);
        idle(1); check("R8 status write ignored", bus_rdata[7], 1);
        bus_addr = 8'hDF; cyc();
        check("R2 clear reg reads zero", bus_rdata, 8'h00);

        idle(3);
        wr(8'hDF, 8'h80);
        check("R7 kick clears", exp_read(), 0);
        idle(7); check("R7 prescaler restarted", bus_rdata, 8'h00);
        idle(1); check("R7 full tick after kick", bus_rdata, 8'h01);

        // service write in the overflow cycle
        for (int i = 0; i < 400 && !(m_pre == M - 1 && m_cnt == CMAX); i++) idle(1);
        wr(8'hDF, 8'h80);
        check("R7 priority no pulse", wdog_rst_o, 0);
        check("R7 priority flag clear", bus_rdata, 8'h00);

        // overflow then power-on reset
        for (int i = 0; i < 400 && !m_flag; i++) idle(1);
        check("R4 second overflow", bus_rdata[7], 1);
        idle(10);
        rst_n = 0; cyc();
        check("R9 flag cleared", bus_rdata, 8'h00);
        check("R9 pulse cleared", wdog_rst_o, 0);
        rst_n = 1;

        // service write inside a running pulse
        for (int i = 0; i < 400 && !m_flag; i++) idle(1);
        wr(8'hDF, 8'h80);
        check("R7 kick in pulse clears flag", bus_rdata, 8'h00);
        n = 1;
        while (wdog_rst_o && n < 50) begin idle(1); if (wdog_rst_o) n++; end
        check("R7 pulse completes", n + 1, L);
        idle(20);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule